// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block recovers asynchronous serial frames from a single receive line. A tick from outside paces it, at either 8 or 16 ticks per bit period. The line first passes through a reset-to-idle synchronizer. The receiver then waits for a falling level and confirms the start bit at mid-bit. It decides each following bit at mid-bit, using either the middle sample alone or a vote over three neighbouring samples. At the stop bit it delivers the word. Frame length (7, 8 or 9 bits) and parity (off, even or odd) are chosen at run time. When parity is on, the parity bit is the top bit of the frame and is removed from the delivered word.

The block holds one received word, with a ready flag that a read strobe clears. Four error flags stay set until cleared: parity, framing, noise and overrun. A write-one-to-clear input clears them. A separate enable input turns reception on and off, and an acknowledge output reports that the receiver is live.

The control is one state machine with five states. OFF is left for IDLE on the cycle after enable is seen high. IDLE goes to START when a tick sees the line low. START goes back to IDLE on a high mid-bit decision (a glitch), or to BITS at the end of the bit period. BITS goes to STOP after the last frame bit's period ends. STOP goes to IDLE at its mid-bit decision, which completes the frame. From any state, a low enable forces OFF on the next clock.

Top module: `uart_frame_rx`

## Requirements
- R1: `en_ack` is high in the cycle after a clock edge that samples `rx_en` high, and low in the cycle after one that samples it low. While `en_ack` is low, line activity produces no word and no flag.
- R2: A tick that sees the synchronized line low in IDLE marks tick 0 of a start bit. If the start bit's mid-bit decision is high, the receiver returns to IDLE with no word and no flag.
- R3: With `os_half`=1 a bit lasts 8 ticks, and with `os_half`=0 it lasts 16. Counting from the start-detect tick, the samples of each bit are taken at in-bit ticks N/2-1, N/2 and N/2+1. The decision falls on tick N/2+1.
- R4: Bits arrive LSB first. `len_sel` 00, 01 and 10 select frames of 7, 8 and 9 bits, and 11 behaves as 01.
- R5: With `par_en`=1 the frame's top bit is the parity bit. `rx_word` then carries the lower frame-length-minus-one bits, and all bits above the data are zero.
- R6: `err_flags[0]` (parity) is set when the data bits plus the parity bit contain an odd count of ones with `par_odd`=0, or an even count with `par_odd`=1.
- R7: With `vote3`=1 a bit's value is the majority of its three samples. With `vote3`=0 only the middle sample counts.
- R8: `err_flags[2]` (noise) is set at frame end if the three samples of any bit, start and stop included, did not all agree with `vote3`=1. It is never set with `vote3`=0.
- R9: `err_flags[1]` (framing) is set when the stop decision is low. The word is still delivered.
- R10: `word_ready` rises in the cycle after the stop decision tick and falls in the cycle after a `data_rd` pulse.
- R11: If a frame completes while `word_ready` is high and no read comes in that cycle, `err_flags[3]` (overrun) is set and the new word is discarded.
- R12: A 1 in a bit of `err_clr` clears that flag. A 0 leaves it unchanged.
- R13: After reset, `word_ready`, `en_ack`, `rx_word` and `err_flags` are all zero.
- R14: The receiver is back in IDLE right after the stop decision, so a start bit that begins two ticks later is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| os_tick | input | 1 | Oversampling tick, one clock wide |
| os_half | input | 1 | 1: 8 ticks per bit, 0: 16 |
| vote3 | input | 1 | 1: three-sample majority, 0: middle sample |
| len_sel | input | 2 | Frame length select (7/8/9 bits) |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1: odd parity, 0: even |
| rxd | input | 1 | Serial receive line, idle high |
| data_rd | input | 1 | Read strobe, clears word_ready |
| err_clr | input | 4 | Write-one-to-clear for err_flags |
| rx_word | output | MAX_LEN | Received data, parity removed |
| word_ready | output | 1 | A word is waiting |
| en_ack | output | 1 | Receiver enabled acknowledge |
| err_flags | output | 4 | [3] overrun, [2] noise, [1] framing, [0] parity |

## Verification
Frames are sent at both oversampling ratios and at all three lengths, with parity off, even and odd. These cases separate wrong bit ordering, wrong parity-bit position and wrong mask width. A single tick is flipped at the middle sample or at the sample before it, in both sampling modes. This shows whether the vote, the single-sample choice and the noise flag use the right sample positions. Short low pulses, low stop bits, unread back-to-back frames, an abort by disable, and a start placed right after a short stop bit exercise the glitch, framing, overrun, enable and resynchronization paths.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_STOP
    } rx_state_e;

    localparam int ERR_W   = 4;
    localparam int ERR_PAR = 0;
    localparam int ERR_FRM = 1;
    localparam int ERR_NSE = 2;
    localparam int ERR_OVR = 3;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    generate
        if (STAGES < 2) begin : g_single
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b1;
                else        q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= {q[STAGES-2:0], din};
            end
            assign dout = q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic maj,
    output logic mid,
    output logic noisy
);

    // hist[0] holds the previous tick's sample, hist[1] the one before it
    logic [1:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hist <= 2'b11;
        else if (tick) hist <= {hist[0], din};
    end

    always_comb begin
        mid   = hist[0];
        maj   = (hist[1] & hist[0]) | (hist[1] & din) | (hist[0] & din);
        noisy = !((hist[1] == hist[0]) && (hist[0] == din));
    end

endmodule

// File: rtl/uart_rx_word.sv
module uart_rx_word #(
    parameter int MAX_LEN = 9
) (
    input  logic [MAX_LEN-1:0] frame,
    input  logic [1:0]         len_sel,
    input  logic               par_en,
    input  logic               par_odd,
    output logic [MAX_LEN-1:0] data,
    output logic               par_err
);

    int  flen;
    int  dlen;
    logic pbit;

    always_comb begin
        unique case (len_sel)
            2'b00:   flen = MAX_LEN - 2;
            2'b10:   flen = MAX_LEN;
            default: flen = MAX_LEN - 1;
        endcase
        dlen = par_en ? flen - 1 : flen;
        for (int i = 0; i < MAX_LEN; i++) begin
            data[i] = (i < dlen) ? frame[i] : 1'b0;
        end
        pbit    = frame[flen-1];
        par_err = par_en & ((^data) ^ pbit ^ par_odd);
    end

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int MAX_LEN     = 9,
    parameter int OS_HI       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_en,
    input  logic               os_tick,
    input  logic               os_half,
    input  logic               vote3,
    input  logic [1:0]         len_sel,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic               rxd,
    input  logic               data_rd,
    input  logic [ERR_W-1:0]   err_clr,
    output logic [MAX_LEN-1:0] rx_word,
    output logic               word_ready,
    output logic               en_ack,
    output logic [ERR_W-1:0]   err_flags
);

    localparam int OS_LO = OS_HI / 2;
    localparam int OS_W  = $clog2(OS_HI);
    localparam int BIT_W = $clog2(MAX_LEN);

    rx_state_e state, state_nxt;

    logic                rxs;
    logic                maj, mid, noisy;
    logic [OS_W-1:0]     cnt, idx_now, last_idx, mid_idx;
    logic [BIT_W-1:0]    bidx, len_m1;
    logic [MAX_LEN-1:0]  frame;
    logic [MAX_LEN-1:0]  word_data;
    logic                par_err;
    logic                noise_acc;
    logic                bit_val, bit_noise;
    logic                decide, wrap, start_seen;
    logic                frame_done, ovr_hit, accept;
    logic [ERR_W-1:0]    err_set;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rxs)
    );

    uart_rx_vote u_vote (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (os_tick),
        .din   (rxs),
        .maj   (maj),
        .mid   (mid),
        .noisy (noisy)
    );

    uart_rx_word #(.MAX_LEN(MAX_LEN)) u_word (
        .frame   (frame),
        .len_sel (len_sel),
        .par_en  (par_en),
        .par_odd (par_odd),
        .data    (word_data),
        .par_err (par_err)
    );

    // bit timing
    always_comb begin
        last_idx   = os_half ? OS_W'(OS_LO - 1) : OS_W'(OS_HI - 1);
        mid_idx    = os_half ? OS_W'(OS_LO / 2) : OS_W'(OS_HI / 2);
        idx_now    = (cnt == last_idx) ? '0 : cnt + OS_W'(1);
        decide     = os_tick && (idx_now == mid_idx + OS_W'(1));
        wrap       = os_tick && (idx_now == '0);
        start_seen = os_tick && !rxs;
        bit_val    = vote3 ? maj : mid;
        bit_noise  = vote3 & noisy;
        unique case (len_sel)
            2'b00:   len_m1 = BIT_W'(MAX_LEN - 3);
            2'b10:   len_m1 = BIT_W'(MAX_LEN - 1);
            default: len_m1 = BIT_W'(MAX_LEN - 2);
        endcase
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:   state_nxt = ST_IDLE;
            ST_IDLE:  if (start_seen) state_nxt = ST_START;
            ST_START: begin
                if (decide && bit_val) state_nxt = ST_IDLE;
                else if (wrap)         state_nxt = ST_BITS;
            end
            ST_BITS:  if (wrap && (bidx == len_m1)) state_nxt = ST_STOP;
            ST_STOP:  if (decide) state_nxt = ST_IDLE;
            default:  state_nxt = ST_OFF;
        endcase
        if (!rx_en) state_nxt = ST_OFF;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // frame completion and flag updates
    always_comb begin
        frame_done = (state == ST_STOP) && decide && rx_en;
        ovr_hit    = frame_done && word_ready && !data_rd;
        accept     = frame_done && !ovr_hit;
        err_set    = '0;
        err_set[ERR_OVR] = ovr_hit;
        err_set[ERR_NSE] = frame_done && (noise_acc || bit_noise);
        err_set[ERR_FRM] = frame_done && !bit_val;
        err_set[ERR_PAR] = frame_done && par_err;
    end

    // counters and frame assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bidx      <= '0;
            frame     <= '0;
            noise_acc <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_seen) begin
                        cnt       <= '0;
                        frame     <= '0;
                        noise_acc <= 1'b0;
                    end
                end
                ST_START: begin
                    if (os_tick) cnt <= idx_now;
                    if (decide)  noise_acc <= noise_acc | bit_noise;
                    if (wrap)    bidx <= '0;
                end
                ST_BITS: begin
                    if (os_tick) cnt <= idx_now;
                    if (decide) begin
                        frame[bidx] <= bit_val;
                        noise_acc   <= noise_acc | bit_noise;
                    end
                    if (wrap) bidx <= bidx + BIT_W'(1);
                end
                ST_STOP: begin
                    if (os_tick) cnt <= idx_now;
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    // held word, ready flag and sticky errors
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word    <= '0;
            word_ready <= 1'b0;
            err_flags  <= '0;
        end else begin
            if (accept)  rx_word <= word_data;
            word_ready <= accept | (word_ready & ~data_rd);
            err_flags  <= (err_flags & ~err_clr) | err_set;
        end
    end

    // outputs decoded from state
    always_comb begin
        en_ack = (state != ST_OFF);
    end

endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk #(
    parameter int MAX_LEN = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_en,
    input logic               en_ack,
    input logic               data_rd,
    input logic               word_ready,
    input logic [MAX_LEN-1:0] rx_word,
    input logic [3:0]         err_flags,
    input logic [3:0]         err_clr,
    input logic               frame_done
);

    // R1
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |=> en_ack);

    // R1
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !en_ack);

    // R11
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && !data_rd) |=> $stable(rx_word));

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !frame_done) |=> !word_ready);

    // R10
    ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_ready) |-> $past(frame_done));

    // R12
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(err_flags) & ~$past(err_clr)) & ~err_flags) == 4'b0000);

endmodule

bind uart_frame_rx uart_frame_rx_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .en_ack     (en_ack),
    .data_rd    (data_rd),
    .word_ready (word_ready),
    .rx_word    (rx_word),
    .err_flags  (err_flags),
    .err_clr    (err_clr),
    .frame_done (frame_done)
);

// File: tb/uart_frame_rx_bench.sv
`timescale 1ns/1ps
module uart_frame_rx_bench;

    localparam int TICK_DIV = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       os_tick = 1'b0;
    logic       os_half = 1'b0;
    logic       vote3 = 1'b0;
    logic [1:0] len_sel = 2'b01;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rxd = 1'b1;
    logic       data_rd = 1'b0;
    logic [3:0] err_clr = 4'b0;
    logic [8:0] rx_word;
    logic       word_ready;
    logic       en_ack;
    logic [3:0] err_flags;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int ph = 0;
    bit done = 0;
    int lvq[$];

    always #2.5 clk = ~clk;

    uart_frame_rx u_uart_frame_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick),
        .os_half(os_half), .vote3(vote3), .len_sel(len_sel), .par_en(par_en),
        .par_odd(par_odd), .rxd(rxd), .data_rd(data_rd), .err_clr(err_clr),
        .rx_word(rx_word), .word_ready(word_ready), .en_ack(en_ack),
        .err_flags(err_flags)
    );

    // tick generator and line player: the line changes right after a tick edge
    always @(negedge clk) begin
        if (os_tick) rxd = (lvq.size() > 0) ? lvq.pop_front() != 0 : 1'b1;
        ph = (ph == TICK_DIV - 1) ? 0 : ph + 1;
        os_tick = (ph == 0);
    end

    // behavioural reference model
    int   m_busy, m_pos, m_a0, m_a1, m_a2, m_nacc, m_fw;
    logic m_rdy, m_ack;
    logic [8:0] m_word;
    logic [3:0] m_err;

    function automatic int ones(input int v, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) c += (v >> i) & 1;
        return c;
    endfunction

    always @(posedge clk) begin
        int n, h, b, w, v, nz, comp, ovr, flen, dlen, dat, pb, perr, stlow;
        if (!rst_n) begin
            m_busy = 0; m_pos = 0; m_nacc = 0; m_fw = 0;
            m_rdy = 0; m_ack = 0; m_word = '0; m_err = '0;
        end else begin
            comp = 0; nz = 0; v = 1; dat = 0; perr = 0; stlow = 0;
            n = os_half ? 8 : 16;
            h = n / 2;
            flen = (len_sel == 2'b00) ? 7 : (len_sel == 2'b10) ? 9 : 8;
            if (!rx_en) begin
                m_busy = 0; m_ack = 0;
            end else if (!m_ack) begin
                m_ack = 1;
            end else if (os_tick) begin
                if (m_busy == 0) begin
                    if (rxd == 1'b0) begin
                        m_busy = 1; m_pos = 0; m_nacc = 0; m_fw = 0;
                    end
                end else begin
                    m_pos++;
                    b = m_pos / n;
                    w = m_pos % n;
                    if (w == h - 1) m_a0 = rxd;
                    if (w == h)     m_a1 = rxd;
                    if (w == h + 1) begin
                        m_a2 = rxd;
                        v  = vote3 ? ((m_a0 + m_a1 + m_a2) >= 2) : m_a1;
                        nz = vote3 && !((m_a0 == m_a1) && (m_a1 == m_a2));
                        if (b == 0) begin
                            if (v != 0) m_busy = 0;
                            else m_nacc |= nz;
                        end else if (b <= flen) begin
                            if (v != 0) m_fw |= (1 << (b - 1));
                            m_nacc |= nz;
                        end else begin
                            m_nacc |= nz;
                            dlen  = par_en ? flen - 1 : flen;
                            dat   = m_fw & ((1 << dlen) - 1);
                            pb    = (m_fw >> (flen - 1)) & 1;
                            perr  = par_en && (((ones(dat, dlen) + pb + par_odd) % 2) != 0);
                            stlow = (v == 0);
                            comp  = 1;
                            m_busy = 0;
                        end
                    end
                end
            end
            ovr = comp && m_rdy && !data_rd;
            m_err = (m_err & ~err_clr) |
                    {ovr != 0, (comp != 0) && (m_nacc != 0), (comp != 0) && (stlow != 0),
                     (comp != 0) && (perr != 0)};
            if (comp && !ovr) begin
                m_word = 9'(dat);
                m_rdy  = 1;
            end else if (data_rd) begin
                m_rdy = 0;
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared++;
            if (en_ack !== m_ack) begin
                mismatched++;
                $display("FAIL R1 en_ack act=%0b exp=%0b t=%0t", en_ack, m_ack, $time);
            end
            if (word_ready !== m_rdy) begin
                mismatched++;
                $display("FAIL R10 word_ready act=%0b exp=%0b t=%0t", word_ready, m_rdy, $time);
            end
            if (rx_word !== m_word) begin
                mismatched++;
                $display("FAIL R4 rx_word act=%h exp=%h t=%0t", rx_word, m_word, $time);
            end
            if (err_flags !== m_err) begin
                mismatched++;
                $display("FAIL R6/R8/R9/R11 err_flags act=%b exp=%b t=%0t", err_flags, m_err, $time);
            end
        end
    end

    task automatic summary();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            mismatched++;
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            summary();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    int g_n = 16;
    int g_l = 8;

    task automatic set_cfg(input bit half, input bit [1:0] ls, input bit pe,
                           input bit po, input bit vt);
        @(negedge clk);
        os_half = half; len_sel = ls; par_en = pe; par_odd = po; vote3 = vt;
        g_n = half ? 8 : 16;
        g_l = (ls == 2'b00) ? 7 : (ls == 2'b10) ? 9 : 8;
    endtask

    function automatic int mkframe(input int d);
        int db, p;
        if (!par_en) return d;
        db = g_l - 1;
        p  = (ones(d, db) + par_odd) % 2;
        return d | (p << db);
    endfunction

    task automatic push_frame(input int fbits, input int stop_lvl, input int stop_ticks,
                              input int flip_k, input int flip_w, input int idle_ticks);
        for (int k = 0; k <= g_l; k++) begin
            int lvl = (k == 0) ? 0 : ((fbits >> (k - 1)) & 1);
            for (int w = 0; w < g_n; w++)
                lvq.push_back(lvl ^ ((k == flip_k && w == flip_w) ? 1 : 0));
        end
        for (int w = 0; w < stop_ticks; w++) lvq.push_back(stop_lvl);
        for (int w = 0; w < idle_ticks; w++) lvq.push_back(1);
    endtask

    task automatic drain();
        while (lvq.size() > 0) @(negedge clk);
        repeat (4 * TICK_DIV) @(negedge clk);
    endtask

    task automatic read_word();
        @(negedge clk); data_rd = 1;
        @(negedge clk); data_rd = 0;
        @(negedge clk);
    endtask

    task automatic clear_err(input logic [3:0] m);
        @(negedge clk); err_clr = m;
        @(negedge clk); err_clr = 4'b0;
        @(negedge clk);
    endtask

    task automatic expect_word(input string req, input int word, input int err);
        check({req, " word_ready"}, word_ready, 1);
        check({req, " rx_word"}, rx_word, word);
        check({req, " err_flags"}, err_flags, err);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R13 reset values
        check("R13 word_ready", word_ready, 0);
        check("R13 en_ack", en_ack, 0);
        check("R13 rx_word", rx_word, 0);
        check("R13 err_flags", err_flags, 0);
        rst_n = 1;
        @(negedge clk);
        // R1 enable handshake
        check("R1 ack before enable", en_ack, 0);
        rx_en = 1;
        @(negedge clk);
        check("R1 ack after enable", en_ack, 1);

        // R4 R3 16x, 8-bit, no parity, single sample
        set_cfg(0, 2'b01, 0, 0, 0);
        push_frame(mkframe('hA5), 1, g_n, -1, 0, 2 * g_n);
        drain();
        expect_word("R4", 'hA5, 0);
        read_word();
        check("R10 read clears ready", word_ready, 0);

        // R5 R3 8x, 7-bit frame with even parity, majority
        set_cfg(1, 2'b00, 1, 0, 1);
        push_frame(mkframe('h2D), 1, g_n, -1, 0, 2 * g_n);
        drain();
        expect_word("R5", 'h2D, 0);
        read_word();

        // R6 9-bit odd parity, good then bad
        set_cfg(0, 2'b10, 1, 1, 1);
        push_frame(mkframe('h3C), 1, g_n, -1, 0, 2 * g_n);
        drain();
        expect_word("R6 good parity", 'h3C, 0);
        read_word();
        push_frame(mkframe('h3C) ^ 'h100, 1, g_n, -1, 0, 2 * g_n);
        drain();
        expect_word("R6 bad parity", 'h3C, 'b0001);
        read_word();
        // R12 zeros leave the flag, a one clears it
        clear_err(4'b1110);
        check("R12 zero bit keeps flag", err_flags, 'b0001);
        clear_err(4'b0001);
        check("R12 one bit clears flag", err_flags, 0);

        // R9 framing error, word still delivered; short low stop
        set_cfg(0, 2'b01, 0, 0, 0);
        push_frame(mkframe('h5A), 0, g_n / 2 + 2, -1, 0, 3 * g_n);
        drain();
        expect_word("R9", 'h5A, 'b0010);
        read_word();
        clear_err(4'b1111);

        // R8 R7 majority rides through a flipped middle sample, noise flagged
        set_cfg(0, 2'b01, 0, 0, 1);
        push_frame('h81, 1, g_n, 3, g_n / 2, 2 * g_n);
        drain();
        expect_word("R8 noise in vote mode", 'h81, 'b0100);
        read_word();
        clear_err(4'b1111);

        // R7 single sample ignores a flip off the middle
        set_cfg(0, 2'b01, 0, 0, 0);
        push_frame('h81, 1, g_n, 3, g_n / 2 - 1, 2 * g_n);
        drain();
        expect_word("R7 off-middle flip ignored", 'h81, 0);
        read_word();
        // R7 R8 single sample follows the middle, no noise flag
        push_frame('h81, 1, g_n, 3, g_n / 2, 2 * g_n);
        drain();
        expect_word("R7 middle flip taken", 'h85, 0);
        read_word();

        // R2 start glitch
        for (int i = 0; i < 3; i++) lvq.push_back(0);
        for (int i = 0; i < 3 * g_n; i++) lvq.push_back(1);
        drain();
        check("R2 glitch no word", word_ready, 0);
        check("R2 glitch no flag", err_flags, 0);

        // R11 overrun keeps the first word
        push_frame('h11, 1, g_n, -1, 0, g_n);
        push_frame('h22, 1, g_n, -1, 0, 2 * g_n);
        drain();
        expect_word("R11 overrun", 'h11, 'b1000);
        read_word();
        clear_err(4'b1111);

        // R1 disable mid-frame aborts it
        push_frame('h77, 1, g_n, -1, 0, 2 * g_n);
        repeat (4 * g_n * TICK_DIV) @(negedge clk);
        rx_en = 0;
        @(negedge clk);
        check("R1 ack drops", en_ack, 0);
        drain();
        rx_en = 1;
        repeat (2) @(negedge clk);
        check("R1 ack back", en_ack, 1);
        check("R1 aborted frame no word", word_ready, 0);

        // R14 a start two ticks after the stop decision
        set_cfg(1, 2'b01, 0, 0, 1);
        push_frame('hC3, 1, g_n / 2 + 2, -1, 0, 0);
        push_frame('h3E, 1, g_n, -1, 0, 2 * g_n);
        while (!word_ready) @(negedge clk);
        check("R14 first word", rx_word, 'hC3);
        read_word();
        while (!word_ready) @(negedge clk);
        check("R14 second word", rx_word, 'h3E);
        check("R14 no errors", err_flags, 0);
        read_word();

        summary();
    end

endmodule